// File: doc/BRIEF.md
# Single-Bus Register Datapath

This block is the register-and-memory half of a small accumulator machine. Six registers and a 4096-word by 16-bit memory share one 16-bit bus. A 3-bit source code picks the one source that drives the bus in each cycle. The address register and the program counter are 12 bits wide, and when either drives the bus its four upper bits read as zero. The data, accumulator, instruction and temporary registers are 16 bits wide.

Each register has its own load, increment and clear strobes. A loading register takes the bus value, except the accumulator, which takes a separate ALU-result input. The control logic and the ALU are outside the block. The memory is always addressed by the address register. Its read data is combinational and appears on the bus under source code 7. A write strobe stores the current bus word on the clock edge.

All interfaces are plain, cycle-level control and data pins. There is no handshake and no back-pressure: every strobe acts on the clock edge at which it is sampled.

Top module: `bus_datapath`

## Requirements
- R1: The bus carries the selected source: code 1 = address register, 2 = program counter, 3 = data register, 4 = accumulator, 5 = instruction register, 6 = temporary register, 7 = memory read data.
- R2: Source code 0 drives 16'h0000 onto the bus.
- R3: The address register and program counter are 12 bits wide. When either drives the bus, bus bits 15..12 are zero, and loading them keeps only bus bits 11..0.
- R4: A register other than the accumulator whose load strobe is high captures the bus value at the clock edge.
- R5: The accumulator's load strobe captures the ALU-result input; the bus value has no effect on the accumulator.
- R6: An increment strobe adds one modulo 2^width (12-bit registers wrap from 12'hFFF to 0).
- R7: Strobe priority within one register: clear, then load, then increment.
- R8: A memory write stores the bus word at the address held in the address register. Memory read data, on source 7, is combinational and taken from the current address register.
- R9: A register with no strobe asserted keeps its value, whatever the bus does.
- R10: An active-low asynchronous reset clears all six registers to zero.
- R11: A bus transfer and an ALU-path transfer can happen in one cycle: with the accumulator on the bus, the data register loads and the accumulator loads the ALU result together, so the two registers swap when the ALU result carries the data register's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 3 | Bus source code (R1, R2) |
| ld_en | input | 6 | Load strobes; bit 0 AR, 1 PC, 2 DR, 3 AC, 4 IR, 5 TR |
| inr_en | input | 6 | Increment strobes, same bit order |
| clr_en | input | 6 | Clear strobes, same bit order |
| mem_we | input | 1 | Memory write strobe |
| alu_result | input | 16 | Word loaded into the accumulator |
| bus_q | output | 16 | Current bus value |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Temporary register |

## Verification
The bus and the memory read data are combinational, so a change of source code or of the address register shows on `bus_q` in the same cycle. The bench checks these one nanosecond after it drives the inputs, well before the next edge. Register strobes and memory writes take effect at the next rising edge. The bench therefore drives them just after an edge and checks the register outputs one nanosecond after the following edge. Reading back a written word takes one edge for the write and none for the read.

// File: rtl/bdp_pkg.sv
`timescale 1ns/1ps
package bdp_pkg;
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_AR   = 3'd1,
    SRC_PC   = 3'd2,
    SRC_DR   = 3'd3,
    SRC_AC   = 3'd4,
    SRC_IR   = 3'd5,
    SRC_TR   = 3'd6,
    SRC_MEM  = 3'd7
  } bus_src_e;

  localparam int NREG   = 6;
  localparam int IDX_AR = 0;
  localparam int IDX_PC = 1;
  localparam int IDX_DR = 2;
  localparam int IDX_AC = 3;
  localparam int IDX_IR = 4;
  localparam int IDX_TR = 5;
endpackage

// File: rtl/bdp_reg.sv
`timescale 1ns/1ps
module bdp_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic         inr,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (ld)  q <= d;
    else if (inr) q <= q + 1'b1;
  end
endmodule

// File: rtl/bdp_mem.sv
`timescale 1ns/1ps
module bdp_mem #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
  end

  assign rdata = store[addr];
endmodule

// File: rtl/bdp_bus_mux.sv
`timescale 1ns/1ps
module bdp_bus_mux
  import bdp_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [2:0]                sel,
  input  logic [NREG-1:0][DW-1:0]   reg_ext,
  input  logic [DW-1:0]             mem_rd,
  output logic [DW-1:0]             bus
);
  always_comb begin
    case (bus_src_e'(sel))
      SRC_AR:  bus = reg_ext[IDX_AR];
      SRC_PC:  bus = reg_ext[IDX_PC];
      SRC_DR:  bus = reg_ext[IDX_DR];
      SRC_AC:  bus = reg_ext[IDX_AC];
      SRC_IR:  bus = reg_ext[IDX_IR];
      SRC_TR:  bus = reg_ext[IDX_TR];
      SRC_MEM: bus = mem_rd;
      default: bus = '0;
    endcase
  end
endmodule

// File: rtl/bus_datapath.sv
`timescale 1ns/1ps
module bus_datapath
  import bdp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_sel,
  input  logic [5:0]        ld_en,
  input  logic [5:0]        inr_en,
  input  logic [5:0]        clr_en,
  input  logic              mem_we,
  input  logic [WORD_W-1:0] alu_result,
  output logic [WORD_W-1:0] bus_q,
  output logic [ADDR_W-1:0] ar_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic [WORD_W-1:0] dr_q,
  output logic [WORD_W-1:0] ac_q,
  output logic [WORD_W-1:0] ir_q,
  output logic [WORD_W-1:0] tr_q
);
  logic [NREG-1:0][WORD_W-1:0] reg_ext;
  logic [WORD_W-1:0]           mem_rd;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam int W = (i == IDX_AR || i == IDX_PC) ? ADDR_W : WORD_W;
    logic [W-1:0] d;
    logic [W-1:0] q;
    if (i == IDX_AC) begin : g_alu_src
      assign d = alu_result[W-1:0];
    end else begin : g_bus_src
      assign d = bus_q[W-1:0];
    end
    bdp_reg #(.W(W)) u_reg (
      .clk (clk),
      .rst_n (rst_n),
      .ld  (ld_en[i]),
      .inr (inr_en[i]),
      .clr (clr_en[i]),
      .d   (d),
      .q   (q)
    );
    assign reg_ext[i] = WORD_W'(q);
  end

  bdp_mem #(.AW(ADDR_W), .DW(WORD_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (ar_q),
    .wdata (bus_q),
    .rdata (mem_rd)
  );

  bdp_bus_mux #(.DW(WORD_W)) u_mux (
    .sel     (bus_sel),
    .reg_ext (reg_ext),
    .mem_rd  (mem_rd),
    .bus     (bus_q)
  );

  assign ar_q = reg_ext[IDX_AR][ADDR_W-1:0];
  assign pc_q = reg_ext[IDX_PC][ADDR_W-1:0];
  assign dr_q = reg_ext[IDX_DR];
  assign ac_q = reg_ext[IDX_AC];
  assign ir_q = reg_ext[IDX_IR];
  assign tr_q = reg_ext[IDX_TR];
endmodule

// File: rtl/bdp_checker.sv
`timescale 1ns/1ps
module bdp_checker #(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        bus_sel,
  input logic [5:0]        ld_en,
  input logic [5:0]        inr_en,
  input logic [5:0]        clr_en,
  input logic              mem_we,
  input logic [WORD_W-1:0] alu_result,
  input logic [WORD_W-1:0] bus_q,
  input logic [ADDR_W-1:0] ar_q,
  input logic [ADDR_W-1:0] pc_q,
  input logic [WORD_W-1:0] dr_q,
  input logic [WORD_W-1:0] ac_q,
  input logic [WORD_W-1:0] ir_q
);
  assert_sel_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel == 3'd0 |-> bus_q == '0);

  assert_narrow_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == 3'd1 || bus_sel == 3'd2) |-> bus_q[WORD_W-1:ADDR_W] == '0);

  assert_dr_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en[2] && !clr_en[2]) |=> dr_q == $past(bus_q));

  assert_ac_alu_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en[3] && !clr_en[3]) |=> ac_q == $past(alu_result));

  assert_pc_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inr_en[1] && !ld_en[1] && !clr_en[1]) |=> pc_q == ADDR_W'($past(pc_q) + 1'b1));

  assert_clr_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en[0] |=> ar_q == '0);

  assert_mem_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == 3'd7 && $past(mem_we) && !$past(ld_en[0]) && !$past(inr_en[0])
     && !$past(clr_en[0])) |-> bus_q == $past(bus_q));

  assert_ir_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en[4] && !inr_en[4] && !clr_en[4]) |=> $stable(ir_q));
endmodule

bind bus_datapath bdp_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/bus_datapath_bench.sv
`timescale 1ns/1ps
module bus_datapath_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_sel = '0;
  logic [5:0]  ld_en = '0, inr_en = '0, clr_en = '0;
  logic        mem_we = 1'b0;
  logic [15:0] alu_result = '0;
  logic [15:0] bus_q, dr_q, ac_q, ir_q, tr_q;
  logic [11:0] ar_q, pc_q;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bus_datapath u_bus_datapath (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .ld_en(ld_en), .inr_en(inr_en),
    .clr_en(clr_en), .mem_we(mem_we), .alu_result(alu_result), .bus_q(bus_q),
    .ar_q(ar_q), .pc_q(pc_q), .dr_q(dr_q), .ac_q(ac_q), .ir_q(ir_q), .tr_q(tr_q)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    ld_en = '0; inr_en = '0; clr_en = '0; mem_we = 1'b0;
  endtask

  task automatic load_ac(input logic [15:0] v);
    alu_result = v; ld_en[3] = 1'b1;
    tick();
  endtask

  task automatic put(input int idx, input logic [15:0] v);
    load_ac(v);
    bus_sel = 3'd4; ld_en[idx] = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    check("R10 ar", {4'h0, ar_q}, 16'h0);
    check("R10 pc", {4'h0, pc_q}, 16'h0);
    check("R10 dr", dr_q, 16'h0);
    check("R10 ac", ac_q, 16'h0);
    check("R10 ir", ir_q, 16'h0);
    check("R10 tr", tr_q, 16'h0);
  endtask

  task automatic t_sel_map();
    put(0, 16'hF111); put(1, 16'hE222); put(2, 16'h3333);
    put(4, 16'h4444); put(5, 16'h5555); load_ac(16'h6666);
    bus_sel = 3'd1; #1; check("R1 R3 sel AR", bus_q, 16'h0111);
    bus_sel = 3'd2; #1; check("R1 R3 sel PC", bus_q, 16'h0222);
    bus_sel = 3'd3; #1; check("R1 sel DR", bus_q, 16'h3333);
    bus_sel = 3'd4; #1; check("R1 sel AC", bus_q, 16'h6666);
    bus_sel = 3'd5; #1; check("R1 R4 sel IR", bus_q, 16'h4444);
    bus_sel = 3'd6; #1; check("R1 R4 sel TR", bus_q, 16'h5555);
    bus_sel = 3'd0; #1; check("R2 sel none", bus_q, 16'h0000);
  endtask

  task automatic t_inc_wrap();
    put(0, 16'hFFFF);
    inr_en[0] = 1'b1; tick();
    check("R6 AR wrap", {4'h0, ar_q}, 16'h0000);
    put(2, 16'hFFFE);
    inr_en[2] = 1'b1; tick();
    check("R6 DR inc", dr_q, 16'hFFFF);
  endtask

  task automatic t_priority();
    put(0, 16'h0123);
    load_ac(16'h0456);
    bus_sel = 3'd4; clr_en[0] = 1'b1; ld_en[0] = 1'b1; inr_en[0] = 1'b1; tick();
    check("R7 clear wins", {4'h0, ar_q}, 16'h0000);
    ld_en[0] = 1'b1; inr_en[0] = 1'b1; tick();
    check("R7 load over inc", {4'h0, ar_q}, 16'h0456);
    inr_en[0] = 1'b1; tick();
    check("R7 inc alone", {4'h0, ar_q}, 16'h0457);
  endtask

  task automatic t_memory();
    put(0, 16'h00A5);
    load_ac(16'hBEEF);
    bus_sel = 3'd4; mem_we = 1'b1; tick();
    bus_sel = 3'd7; #1; check("R8 readback", bus_q, 16'hBEEF);
    put(0, 16'h00A6);
    load_ac(16'h1234);
    bus_sel = 3'd4; mem_we = 1'b1; tick();
    bus_sel = 3'd7; #1; check("R8 second word", bus_q, 16'h1234);
    put(0, 16'h00A5);
    bus_sel = 3'd7; #1; check("R8 addressed by AR", bus_q, 16'hBEEF);
  endtask

  task automatic t_hold_and_ac();
    put(4, 16'h5A5A);
    put(2, 16'h1111);
    alu_result = 16'h2222; bus_sel = 3'd3; ld_en[3] = 1'b1; tick();
    check("R5 AC from ALU", ac_q, 16'h2222);
    alu_result = 16'h9999; bus_sel = 3'd3; tick();
    check("R9 AC hold", ac_q, 16'h2222);
    check("R9 IR hold", ir_q, 16'h5A5A);
  endtask

  task automatic t_swap();
    put(2, 16'h5555);
    load_ac(16'hAAAA);
    alu_result = dr_q; bus_sel = 3'd4; ld_en[2] = 1'b1; ld_en[3] = 1'b1; tick();
    check("R11 DR takes AC", dr_q, 16'hAAAA);
    check("R11 AC takes DR", ac_q, 16'h5555);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #55;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    #1;
    t_sel_map();
    t_inc_wrap();
    t_priority();
    t_memory();
    t_hold_and_ac();
    t_swap();
    done = 1'b1;
    report();
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end
endmodule